// File: doc/BRIEF.md
# Control Word and Snapshot Register Bank

This block sits on a plain single-cycle address/data bus and holds one 32-bit control word. Software can change that word in three ways, each through its own address: replace it whole, raise the bits that are 1 in the data, or drop the bits that are 1 in the data. Because set and clear are separate writes, software can change one field without first reading the word back, and the result does not depend on when other writers touch it.

A command address turns each written 1 into a single-cycle strobe: clear the event counters, capture a snapshot, or fire a software trigger. The block keeps a free-running timestamp and three event counters (accepted triggers, input triggers, pulser events) that count strobes on `evt_i`. A capture strobe copies the timestamp and all three counters into read-only shadow registers in the same clock edge, so one capture gives a consistent set of values that software can read at its own pace.

Strobes come from a two-state sequencer. `CMD_IDLE` is the rest state. The transition *arm* (a command write with at least one bit set) leads from `CMD_IDLE` to `CMD_FIRE`. In `CMD_FIRE` the captured bits drive the strobes for exactly one cycle. From there *rearm* (another non-zero command write) stays in `CMD_FIRE` with the new bits, and *drain* (anything else) returns to `CMD_IDLE`.

Top module: `ctrl_bank`

## Requirements
- R1: A write to address 0x3F replaces the control word with the write data. The new value is on `ctrl_o` from the next cycle.
- R2: A write to address 0x3E ORs the write data into the control word.
- R3: A write to address 0x3D clears each control word bit whose write-data bit is 1 (word AND NOT data).
- R4: A read returns data and raises `rd_valid` exactly one cycle after `rd_en`. Reads of 0x3D, 0x3E and 0x3F all return the current control word.
- R5: A write to the command address 0x2B gives a one-cycle strobe in the cycle after the write for each data bit that is 1: bit 0 drives `cnt_clr_o`, bit 1 drives `snap_o` and bit 2 drives `swtrig_o`. A read of 0x2B returns 0.
- R6: Counter k counts clock cycles in which `evt_i[k]` is 1. A counter-clear strobe sets all three counters to 0.
- R7: A capture strobe copies the timestamp to the shadow at 0x100 and counters 0, 1 and 2 to 0x101, 0x102 and 0x103. The timestamp goes up by one every cycle, so two captures taken N cycles apart differ by N.
- R8: Shadow registers keep their values until the next capture strobe, whatever events arrive in between.
- R9: When clear and capture are written together, the capture takes the counter values from before the clear, and the counters then start again from 0.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R11: After reset the control word, all strobes and all shadow registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Word address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid when `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| evt_i | input | 3 | Event strobes: accepted trigger, input trigger, pulser |
| ctrl_o | output | 32 | Current control word |
| cnt_clr_o | output | 1 | Counter-clear strobe |
| snap_o | output | 1 | Capture strobe |
| swtrig_o | output | 1 | Software trigger strobe |

## Verification
The hardest case to reach is a clear and a capture in the same cycle. From the ports it looks like any other capture unless the counters hold non-zero values beforehand, so the bench first drives a known number of events on each strobe, then writes both command bits in one access. It reads the shadows, expecting the values from before the clear, and then captures again with no events in between, expecting zeros. The timestamp cannot be predicted from reset, so the bench places two captures a known number of cycles apart and checks the difference.

// File: rtl/ctrl_bank_pkg.sv
package ctrl_bank_pkg;
    localparam int A_CLR  = 'h3D;
    localparam int A_SET  = 'h3E;
    localparam int A_LOAD = 'h3F;
    localparam int A_CMD  = 'h2B;
    localparam int A_SNAP = 'h100;

    localparam int CMD_W   = 3;
    localparam int CB_CLR  = 0;
    localparam int CB_SNAP = 1;
    localparam int CB_TRIG = 2;

    typedef enum logic [1:0] {WOP_NONE, WOP_CLR, WOP_SET, WOP_LOAD} wop_t;
    typedef enum logic {CMD_IDLE, CMD_FIRE} cmd_state_t;
endpackage

// File: rtl/ctrl_word.sv
module ctrl_word
    import ctrl_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wop_t              op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            unique case (op)
                WOP_CLR:  word_q <= word_q & ~wdata;
                WOP_SET:  word_q <= word_q | wdata;
                WOP_LOAD: word_q <= wdata;
                default:  word_q <= word_q;
            endcase
        end
    end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import ctrl_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_bits,
    output logic [CMD_W-1:0] pulses
);
    cmd_state_t       state_q, state_d;
    logic [CMD_W-1:0] bits_q;
    logic             arm;

    assign arm = cmd_wr && (|cmd_bits);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: state_d = arm ? CMD_FIRE : CMD_IDLE;
            CMD_FIRE: state_d = arm ? CMD_FIRE : CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMD_IDLE;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= arm ? cmd_bits : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            CMD_FIRE: pulses = bits_q;
            default:  pulses = '0;
        endcase
    end
endmodule

// File: rtl/snap_counters.sv
module snap_counters #(
    parameter int NUM_CNT = 3,
    parameter int CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CNT-1:0]            evt,
    input  logic                          clr,
    input  logic                          snap,
    output logic [CNT_W-1:0]              snap_ts,
    output logic [NUM_CNT-1:0][CNT_W-1:0] snap_cnt
);
    logic [CNT_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q    <= '0;
            snap_ts <= '0;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (snap) snap_ts <= ts_q;
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q       <= '0;
                snap_cnt[k] <= '0;
            end else begin
                // capture samples the pre-clear value in the same edge
                if (snap) snap_cnt[k] <= cnt_q;
                if (clr)         cnt_q <= '0;
                else if (evt[k]) cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank
    import ctrl_bank_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_CNT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    input  logic [NUM_CNT-1:0] evt_i,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic               cnt_clr_o,
    output logic               snap_o,
    output logic               swtrig_o
);
    localparam logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(A_CLR);
    localparam logic [ADDR_W-1:0] ADR_SET  = ADDR_W'(A_SET);
    localparam logic [ADDR_W-1:0] ADR_LOAD = ADDR_W'(A_LOAD);
    localparam logic [ADDR_W-1:0] ADR_CMD  = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] ADR_SNAP = ADDR_W'(A_SNAP);

    wop_t                          op;
    logic [CMD_W-1:0]              pulses;
    logic [DATA_W-1:0]             snap_ts;
    logic [NUM_CNT-1:0][DATA_W-1:0] snap_cnt;
    logic [DATA_W-1:0]             rd_d;

    always_comb begin
        op = WOP_NONE;
        if (wr_en) begin
            if (addr == ADR_CLR)       op = WOP_CLR;
            else if (addr == ADR_SET)  op = WOP_SET;
            else if (addr == ADR_LOAD) op = WOP_LOAD;
        end
    end

    ctrl_word #(.DATA_W(DATA_W)) u_word (
        .clk(clk), .rst(rst), .op(op), .wdata(wdata), .word_q(ctrl_o)
    );

    cmd_seq u_seq (
        .clk(clk), .rst(rst),
        .cmd_wr(wr_en && (addr == ADR_CMD)),
        .cmd_bits(wdata[CMD_W-1:0]),
        .pulses(pulses)
    );

    assign cnt_clr_o = pulses[CB_CLR];
    assign snap_o    = pulses[CB_SNAP];
    assign swtrig_o  = pulses[CB_TRIG];

    snap_counters #(.NUM_CNT(NUM_CNT), .CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .evt(evt_i),
        .clr(cnt_clr_o), .snap(snap_o),
        .snap_ts(snap_ts), .snap_cnt(snap_cnt)
    );

    always_comb begin
        rd_d = '0;
        if (addr == ADR_CLR || addr == ADR_SET || addr == ADR_LOAD) rd_d = ctrl_o;
        if (addr == ADR_SNAP) rd_d = snap_ts;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADR_SNAP + ADDR_W'(i + 1)) rd_d = snap_cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_d : '0;
        end
    end
endmodule

// File: rtl/ctrl_bank_chk.sv
module ctrl_bank_chk
    import ctrl_bank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] ctrl_o,
    input logic              swtrig_o
);
    // R1
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(A_LOAD)) |=> ctrl_o == $past(wdata));

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(A_SET)) |=> ctrl_o == ($past(ctrl_o) | $past(wdata)));

    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(A_CLR)) |=> ctrl_o == ($past(ctrl_o) & ~$past(wdata)));

    // R4
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R4
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R5
    trig_src_chk: assert property (@(posedge clk) disable iff (rst)
        swtrig_o |-> $past(wr_en && addr == ADDR_W'(A_CMD) && wdata[CB_TRIG]));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr < ADDR_W'(A_CMD)) |=> rd_data == '0);

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr < ADDR_W'(A_CMD)) |=> $stable(ctrl_o));
endmodule

bind ctrl_bank ctrl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .ctrl_o(ctrl_o), .swtrig_o(swtrig_o)
);

// File: tb/sim_ctrl_bank.sv
module sim_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [2:0]  evt_i = '0;
    logic [31:0] ctrl_o;
    logic        cnt_clr_o, snap_o, swtrig_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctrl_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .evt_i(evt_i),
        .ctrl_o(ctrl_o), .cnt_clr_o(cnt_clr_o), .snap_o(snap_o), .swtrig_o(swtrig_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 rd_valid", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic command(input logic [31:0] bits);
        bus_wr(12'h2B, bits);
        @(negedge clk);
    endtask

    task automatic pulse_evt(input int k, input int times);
        for (int i = 0; i < times; i++) begin
            evt_i[k] = 1'b1;
            @(negedge clk);
            evt_i[k] = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R11 ctrl_o", ctrl_o, 32'h0);
        chk("R11 strobes", {29'b0, cnt_clr_o, snap_o, swtrig_o}, 32'h0);
        for (int a = 'h100; a <= 'h103; a++) begin
            bus_rd(12'(a), v);
            chk("R11 shadow", v, 32'h0);
        end
    endtask

    task automatic t_word_ops;
        logic [31:0] v;
        bus_wr(12'h3F, 32'hA5A5_0F0F);
        chk("R1 load", ctrl_o, 32'hA5A5_0F0F);
        bus_wr(12'h3E, 32'h0000_00F0);
        chk("R2 set", ctrl_o, 32'hA5A5_0FFF);
        bus_wr(12'h3D, 32'hA500_0001);
        chk("R3 clear", ctrl_o, 32'h00A5_0FFE);
        bus_rd(12'h3D, v); chk("R4 read 3D", v, 32'h00A5_0FFE);
        bus_rd(12'h3E, v); chk("R4 read 3E", v, 32'h00A5_0FFE);
        bus_rd(12'h3F, v); chk("R4 read 3F", v, 32'h00A5_0FFE);
    endtask

    task automatic t_cmd_pulse;
        logic [31:0] v;
        bus_wr(12'h2B, 32'h4);
        chk("R5 trig high", {31'b0, swtrig_o}, 32'd1);
        chk("R5 others low", {30'b0, cnt_clr_o, snap_o}, 32'd0);
        @(negedge clk);
        chk("R5 trig one cycle", {31'b0, swtrig_o}, 32'd0);
        bus_rd(12'h2B, v);
        chk("R5 read cmd", v, 32'h0);
    endtask

    task automatic t_counts;
        logic [31:0] v;
        command(32'h1);
        pulse_evt(0, 5); pulse_evt(1, 3); pulse_evt(2, 1);
        command(32'h2);
        bus_rd(12'h101, v); chk("R6 R7 cnt0", v, 32'd5);
        bus_rd(12'h102, v); chk("R6 R7 cnt1", v, 32'd3);
        bus_rd(12'h103, v); chk("R6 R7 cnt2", v, 32'd1);
        pulse_evt(0, 4);
        bus_rd(12'h101, v); chk("R8 shadow held", v, 32'd5);
    endtask

    task automatic t_clr_and_snap;
        logic [31:0] v;
        bus_wr(12'h2B, 32'h3);
        chk("R9 both strobes", {30'b0, cnt_clr_o, snap_o}, 32'h3);
        @(negedge clk);
        bus_rd(12'h101, v); chk("R9 pre-clear cnt0", v, 32'd9);
        bus_rd(12'h102, v); chk("R9 pre-clear cnt1", v, 32'd3);
        command(32'h2);
        bus_rd(12'h101, v); chk("R9 R6 cleared cnt0", v, 32'd0);
        bus_rd(12'h103, v); chk("R9 R6 cleared cnt2", v, 32'd0);
    endtask

    task automatic t_timestamp;
        logic [31:0] a, b;
        command(32'h2);
        bus_rd(12'h100, a);
        repeat (4) @(negedge clk);
        command(32'h2);
        bus_rd(12'h100, b);
        chk("R7 timestamp gap", b - a, 32'd7);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_wr(12'h3C, 32'hFFFF_FFFF);
        bus_wr(12'h104, 32'h1234_5678);
        chk("R10 write ignored", ctrl_o, 32'h00A5_0FFE);
        bus_rd(12'h3C, v); chk("R10 read 3C", v, 32'h0);
        bus_rd(12'h104, v); chk("R10 read 104", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_word_ops;
        t_cmd_pulse;
        t_counts;
        t_clr_and_snap;
        t_timestamp;
        t_unmapped;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule